// File: doc/BRIEF.md
# UART Modem Control, Status and Diagnostic Loop-Back

This block is the modem side of a UART channel. It keeps the modem control register, whose low bits drive the four outgoing handshake lines, and the modem status register. The status register reports the present level of the four incoming handshake lines, and it keeps a sticky change flag for each of them. It also steers the serial data lines between the external pins and the UART shifters, which are outside this block.

A diagnostic loop-back mode is selected by one control bit. In that mode the outgoing handshake pins go inactive and the TX pin idles high. The incoming pins stop affecting the status register, and each control bit is cross-wired onto one status input. The transmitter output is folded straight back into the receiver input. Change flags and the modem interrupt keep working in this mode, so firmware can exercise the whole status path from the register interface alone.

All handshake signals are active-high inside and at the ports. External handshake inputs pass through a synchronizer of `SYNC_STAGES` flops before they reach the status logic.

Top module: `modem_loop_ctrl`

## Requirements
- R1: A cycle with `ctl_wr` high loads `ctl_wdata[4:0]` into the control register at that clock edge. `ctl_rdata` returns the stored five bits in bits 4:0, and bits 7:5 always read 0. The bit roles are: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loop-back enable.
- R2: With loop-back off, `dtr_o`, `rts_o`, `out1_o` and `out2_o` equal control bits 0, 1, 2 and 3.
- R3: With loop-back on, `dtr_o`, `rts_o`, `out1_o` and `out2_o` are 0 and `tx_pin` is 1.
- R4: With loop-back off, `tx_pin` follows `tx_core` and `rx_core` follows `rx_pin`, both combinationally. With loop-back on, `rx_core` follows `tx_core` and `rx_pin` has no effect.
- R5: With loop-back off, status bits 4, 5, 6 and 7 hold the levels of `cts_i`, `dsr_i`, `ri_i` and `cd_i`. A pin change shows there at the (SYNC_STAGES+1)-th rising edge after it.
- R6: With loop-back on, status bit 4 takes control bit 1 (RTS), bit 5 takes control bit 0 (DTR), bit 6 takes control bit 2, and bit 7 takes control bit 3, one edge after the control register changes. The external handshake pins have no effect on the status register.
- R7: Status bits 0, 1 and 3 set in the same edge that status bit 4, 5 or 7 changes in either direction. They stay set until cleared.
- R8: Status bit 2 sets only when status bit 6 goes from 1 to 0. A rise of bit 6 leaves it unchanged.
- R9: A cycle with `sts_rd` high returns the current status on `sts_rdata` and clears bits 3:0 at that edge. A change detected in that same edge sets its bit anyway.
- R10: `modem_irq` is 1 exactly when `modem_ie` is 1 and at least one of status bits 3:0 is 1.
- R11: After a clock edge with `rst_n` low, the control register, the status register and `modem_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| sts_rd | input | 1 | Status register read strobe (clears change flags) |
| sts_rdata | output | 8 | Status register read value |
| modem_ie | input | 1 | Modem-status interrupt enable |
| modem_irq | output | 1 | Modem-status interrupt |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| dsr_i | input | 1 | Data-set-ready pin, asynchronous |
| ri_i | input | 1 | Ring-indicator pin, asynchronous |
| cd_i | input | 1 | Carrier-detect pin, asynchronous |
| dtr_o | output | 1 | Data-terminal-ready pin |
| rts_o | output | 1 | Request-to-send pin |
| out1_o | output | 1 | General output 1 pin |
| out2_o | output | 1 | General output 2 pin |
| tx_core | input | 1 | Serial output of the transmit shifter |
| tx_pin | output | 1 | Serial TX pin |
| rx_pin | input | 1 | Serial RX pin |
| rx_core | output | 1 | Serial input to the receive shifter |

## Verification
A status read and a newly detected line change can land in the same clock edge. In that edge one function clears the change flags while the other sets one. The bench provokes this by holding `sts_rd` high while it toggles a handshake pin (or a control bit in loop-back), and it also makes the collision many times over under random read strobes. In the edge after the collision the flag for the changed line must still be set and the others must be clear. A cycle-level reference model in the bench, written from the requirements, judges every cycle, and the change-flag checks are tagged with the read-clear requirement whenever a read was issued in that edge.

// File: rtl/modem_loop_pkg.sv
// Package: bit positions shared by the modem control/status path.
// Assumes: status state bits sit 4 above their change flags.
package modem_loop_pkg;
    // line index inside the 4-bit status input vector
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_CD  = 3;
    localparam int N_LINES = 4;

    // control register bit roles
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;
    localparam int CTL_W   = 5;

    localparam int REG_W   = 8;
endpackage

// File: rtl/mdm_sync.sv
// Module: mdm_sync
// Brings W asynchronous inputs into the clock domain through a chain
// of STAGES flops per bit. Assumes STAGES >= 1; output resets to 0.
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // capture the raw pin levels
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // shift one stage further along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
// Module: mdm_ctl_reg
// Holds the control register, drives the outgoing handshake pins and
// steers the serial lines. In loop-back the pins go inactive, TX idles
// high and the transmitter is folded onto the receiver input. It also
// presents the control bits re-mapped onto status line order.
module mdm_ctl_reg
    import modem_loop_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    input  logic               tx_core,
    input  logic               rx_pin,
    output logic               tx_pin,
    output logic               rx_core,
    output logic               dtr_o,
    output logic               rts_o,
    output logic               out1_o,
    output logic               out2_o,
    output logic               loop_on,
    output logic [N_LINES-1:0] loop_lines
);
    logic [CTL_W-1:0] ctl_q;

    // control register: load low bits on a write
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= '0;
        else if (wr) ctl_q <= wdata[CTL_W-1:0];
    end

    assign loop_on = ctl_q[CB_LOOP];
    assign rdata   = {{(REG_W-CTL_W){1'b0}}, ctl_q};

    // outgoing pins: driven inactive while looped back
    always_comb begin
        dtr_o  = ctl_q[CB_DTR]  & ~loop_on;
        rts_o  = ctl_q[CB_RTS]  & ~loop_on;
        out1_o = ctl_q[CB_OUT1] & ~loop_on;
        out2_o = ctl_q[CB_OUT2] & ~loop_on;
    end

    // serial steering: TX idles at mark and RX is fed from TX in loop-back
    always_comb begin
        tx_pin  = loop_on ? 1'b1    : tx_core;
        rx_core = loop_on ? tx_core : rx_pin;
    end

    // cross-wiring of control bits onto the status lines
    always_comb begin
        loop_lines         = '0;
        loop_lines[LN_CTS] = ctl_q[CB_RTS];
        loop_lines[LN_DSR] = ctl_q[CB_DTR];
        loop_lines[LN_RI]  = ctl_q[CB_OUT1];
        loop_lines[LN_CD]  = ctl_q[CB_OUT2];
    end
endmodule

// File: rtl/mdm_status.sv
// Module: mdm_status
// Status register: registered line state in the upper nibble and sticky
// change flags in the lower nibble. The ring line flags only its
// trailing (1->0) edge; the others flag any change. A read clears the
// flags, but a change detected in the same edge still sets its flag.
module mdm_status
    import modem_loop_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic               rd,
    output logic [REG_W-1:0]   rdata,
    output logic               any_flag
);
    logic [N_LINES-1:0] state_q;
    logic [N_LINES-1:0] flag_q;
    logic [N_LINES-1:0] hit;

    // line state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= lines;
    end

    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_det
            if (g == LN_RI) begin : g_trail
                // ring: trailing edge only
                always_comb hit[g] = state_q[g] & ~lines[g];
            end else begin : g_any
                // other lines: either direction
                always_comb hit[g] = state_q[g] ^ lines[g];
            end
        end
    endgenerate

    // change flags: set beats read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (rd ? '0 : flag_q) | hit;
    end

    assign rdata    = {state_q, flag_q};
    assign any_flag = |flag_q;
endmodule

// File: rtl/modem_loop_ctrl.sv
// Module: modem_loop_ctrl (top)
// Modem control/status path with diagnostic loop-back. External inputs
// are synchronized; in loop-back the status logic sees the control bits
// instead of the pins. The interrupt is a level from the change flags
// gated by the enable input.
module modem_loop_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata,
    input  logic       modem_ie,
    output logic       modem_irq,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       ri_i,
    input  logic       cd_i,
    output logic       dtr_o,
    output logic       rts_o,
    output logic       out1_o,
    output logic       out2_o,
    input  logic       tx_core,
    output logic       tx_pin,
    input  logic       rx_pin,
    output logic       rx_core
);
    import modem_loop_pkg::*;

    logic [N_LINES-1:0] pin_raw;
    logic [N_LINES-1:0] pin_sync;
    logic [N_LINES-1:0] loop_lines;
    logic [N_LINES-1:0] sel_lines;
    logic               loop_on;
    logic               any_flag;

    // gather external lines in status order
    always_comb begin
        pin_raw         = '0;
        pin_raw[LN_CTS] = cts_i;
        pin_raw[LN_DSR] = dsr_i;
        pin_raw[LN_RI]  = ri_i;
        pin_raw[LN_CD]  = cd_i;
    end

    mdm_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_sync)
    );

    mdm_ctl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (ctl_wr),
        .wdata      (ctl_wdata),
        .rdata      (ctl_rdata),
        .tx_core    (tx_core),
        .rx_pin     (rx_pin),
        .tx_pin     (tx_pin),
        .rx_core    (rx_core),
        .dtr_o      (dtr_o),
        .rts_o      (rts_o),
        .out1_o     (out1_o),
        .out2_o     (out2_o),
        .loop_on    (loop_on),
        .loop_lines (loop_lines)
    );

    // status source select: pins are isolated in loop-back
    always_comb sel_lines = loop_on ? loop_lines : pin_sync;

    mdm_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (sel_lines),
        .rd       (sts_rd),
        .rdata    (sts_rdata),
        .any_flag (any_flag)
    );

    // interrupt level
    always_comb modem_irq = modem_ie & any_flag;
endmodule

// File: rtl/modem_loop_ctrl_chk.sv
// Module: modem_loop_ctrl_chk
// Port-level temporal checks for modem_loop_ctrl, attached by bind.
module modem_loop_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl_rdata,
    input logic       sts_rd,
    input logic [7:0] sts_rdata,
    input logic       modem_ie,
    input logic       modem_irq,
    input logic       dtr_o,
    input logic       rts_o,
    input logic       out1_o,
    input logic       out2_o,
    input logic       tx_pin
);
    logic loop;
    assign loop = ctl_rdata[4];

    // R1: upper control bits always read 0
    p_ctl_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7:5] == 3'b000);

    // R3: pins inactive and TX at mark while looped back
    p_loop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loop |-> ({dtr_o, rts_o, out1_o, out2_o} == 4'b0000 && tx_pin));

    // R6: looped status state mirrors stable control bits
    p_loop_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (loop && $past(loop) && $stable(ctl_rdata)) |->
        (sts_rdata[7:4] == {ctl_rdata[3], ctl_rdata[2], ctl_rdata[0], ctl_rdata[1]}));

    // R7: a CTS, DSR or CD state change carries its flag
    p_cts_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rdata[4] != $past(sts_rdata[4])) |-> sts_rdata[0]);
    p_dsr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rdata[5] != $past(sts_rdata[5])) |-> sts_rdata[1]);
    p_cd_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rdata[7] != $past(sts_rdata[7])) |-> sts_rdata[3]);

    // R8: ring trailing edge sets its flag; a rise alone never does
    p_ri_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_rdata[6]) |-> sts_rdata[2]);
    p_ri_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sts_rdata[6]) && !$past(sts_rdata[2])) |-> !sts_rdata[2]);

    // R9: flags never appear without a state change, and a read with no change clears them
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sts_rd) && $stable(sts_rdata[7:4])) |-> (sts_rdata[3:0] == 4'b0000));

    // R10: interrupt is the gated OR of the flags
    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        modem_irq == (modem_ie && (sts_rdata[3:0] != 4'b0000)));
endmodule

bind modem_loop_ctrl modem_loop_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rdata (ctl_rdata),
    .sts_rd    (sts_rd),
    .sts_rdata (sts_rdata),
    .modem_ie  (modem_ie),
    .modem_irq (modem_irq),
    .dtr_o     (dtr_o),
    .rts_o     (rts_o),
    .out1_o    (out1_o),
    .out2_o    (out2_o),
    .tx_pin    (tx_pin)
);

// File: tb/modem_loop_ctrl_tb.sv
// Bench for modem_loop_ctrl: seeded random stimulus plus directed
// corners, compared each cycle against a requirement-level model.
module modem_loop_ctrl_tb;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       modem_ie = 1'b0;
    logic       modem_irq;
    logic       cts_i = 1'b0, dsr_i = 1'b0, ri_i = 1'b0, cd_i = 1'b0;
    logic       dtr_o, rts_o, out1_o, out2_o;
    logic       tx_core = 1'b1, tx_pin, rx_pin = 1'b1, rx_core;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    modem_loop_ctrl #(.SYNC_STAGES(SYNC)) u_dut (.*);

    // reference model state: pins in order {cd, ri, dsr, cts}
    logic [3:0] m_s1, m_s2, m_state, m_flag;
    logic [4:0] m_ctl;
    bit         m_rd_prev;

    function automatic logic [3:0] lines_of(input logic [4:0] c, input logic [3:0] syn);
        if (c[4]) return {c[3], c[2], c[0], c[1]};
        return syn;
    endfunction

    function automatic logic [3:0] hits(input logic [3:0] old, input logic [3:0] nw);
        logic [3:0] h;
        h = old ^ nw;
        h[2] = old[2] & ~nw[2];
        return h;
    endfunction

    // model update at each edge, from the stable inputs driven at negedge
    always @(posedge clk) begin
        logic [3:0] cur;
        cur = lines_of(m_ctl, m_s2);
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_state <= '0; m_flag <= '0; m_ctl <= '0;
        end else begin
            m_s1    <= {cd_i, ri_i, dsr_i, cts_i};
            m_s2    <= m_s1;
            m_state <= cur;
            m_flag  <= (sts_rd ? 4'b0 : m_flag) | hits(m_state, cur);
            if (ctl_wr) m_ctl <= ctl_wdata[4:0];
        end
        m_rd_prev <= sts_rd;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every port against the model (called at negedge)
    task automatic check_all();
        bit lp;
        lp = m_ctl[4];
        chk("R1 ctl readback", ctl_rdata, {3'b000, m_ctl});
        if (lp) begin
            chk("R3 pins inactive", {4'b0, dtr_o, rts_o, out1_o, out2_o}, 8'h00);
            chk("R3 tx mark", {7'b0, tx_pin}, 8'h01);
            chk("R4 rx folded", {7'b0, rx_core}, {7'b0, tx_core});
            chk("R6 looped state", {4'b0, sts_rdata[7:4]}, {4'b0, m_state});
        end else begin
            chk("R2 pins", {4'b0, dtr_o, rts_o, out1_o, out2_o},
                {4'b0, m_ctl[0], m_ctl[1], m_ctl[2], m_ctl[3]});
            chk("R4 tx pass", {7'b0, tx_pin}, {7'b0, tx_core});
            chk("R4 rx pass", {7'b0, rx_core}, {7'b0, rx_pin});
            chk("R5 pin state", {4'b0, sts_rdata[7:4]}, {4'b0, m_state});
        end
        if (m_rd_prev)
            chk("R9 flags after read", {4'b0, sts_rdata[3:0]}, {4'b0, m_flag});
        else begin
            chk("R7 change flags", {5'b0, sts_rdata[3], sts_rdata[1:0]},
                {5'b0, m_flag[3], m_flag[1:0]});
            chk("R8 ring flag", {7'b0, sts_rdata[2]}, {7'b0, m_flag[2]});
        end
        chk("R10 irq", {7'b0, modem_irq}, {7'b0, modem_ie & (|m_flag)});
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_inputs();
        ctl_wr = 1'b0; sts_rd = 1'b0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0C0D);
        // reset
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 ctl reset", ctl_rdata, 8'h00);
        chk("R11 sts reset", sts_rdata, 8'h00);
        chk("R11 irq reset", {7'b0, modem_irq}, 8'h00);
        rst_n = 1'b1;
        step();

        // directed R8: ring rise then fall via loop-back control bit 2
        modem_ie = 1'b1;
        ctl_wr = 1'b1; ctl_wdata = 8'h14; step();      // loop on, OUT1=1 -> ri=1
        idle_inputs(); step(); step();
        sts_rd = 1'b1; step(); sts_rd = 1'b0; step();
        chk("R8 no flag on ring rise", {7'b0, sts_rdata[2]}, 8'h00);
        ctl_wr = 1'b1; ctl_wdata = 8'h10; step();      // ri falls
        idle_inputs(); step();
        chk("R8 flag on ring fall", {7'b0, sts_rdata[2]}, 8'h01);
        chk("R10 irq from ring", {7'b0, modem_irq}, 8'h01);

        // directed R6: external pins ignored in loop-back
        cts_i = 1'b1; dsr_i = 1'b1; ri_i = 1'b1; cd_i = 1'b1;
        sts_rd = 1'b1; step(); sts_rd = 1'b0;
        repeat (5) step();
        chk("R6 pins ignored", sts_rdata, 8'h00);

        // directed R9: read and a new change in the same edge (RTS -> CTS)
        ctl_wr = 1'b1; ctl_wdata = 8'h11; step();      // ctl_q RTS=0? bit0 DTR=1
        idle_inputs(); step();                          // DSR flag now set
        ctl_wr = 1'b1; ctl_wdata = 8'h13; sts_rd = 1'b1; step(); // RTS=1 load
        ctl_wr = 1'b0; sts_rd = 1'b1; step();          // read edge + CTS change edge
        sts_rd = 1'b0; step();
        chk("R9 set wins over clear", {4'b0, sts_rdata[3:0]}, 8'h01);

        // leave loop-back; pins now drive state
        ctl_wr = 1'b1; ctl_wdata = 8'h0F; step();
        idle_inputs();
        repeat (SYNC + 2) step();
        chk("R5 pins after sync", {4'b0, sts_rdata[7:4]}, 8'h0F);
        chk("R2 pins follow ctl", {4'b0, dtr_o, rts_o, out1_o, out2_o}, 8'h0F);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] r;
            r = 8'($urandom);
            ctl_wr    = (r[2:0] == 3'd0);
            ctl_wdata = 8'($urandom);
            if (i < 2000) ctl_wdata[4] = 1'b0;          // first half: mostly pins
            sts_rd    = r[3] & r[4];
            modem_ie  = r[5] | r[6];
            if (r[7]) {cd_i, ri_i, dsr_i, cts_i} = 4'($urandom);
            tx_core   = 1'($urandom);
            rx_pin    = 1'($urandom);
            step();
        end
        idle_inputs();
        step();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        #(150_000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule